// File: doc/BRIEF.md
# Multi-Slot Execute Latency Scheduler

This block models the timing of an arithmetic execute stage that serves several issue slots side by side. Each slot owns a small queue of operation descriptors (class code, result tag, warp index, end-of-packet bit, fetch-stall bit). In every cycle each slot with a non-empty queue looks at its oldest entry, picks a completion delay from the operation's class, and books the tag into a per-slot completion line. When the delay has elapsed the tag appears on that slot's completion output. No arithmetic is performed: only the timing, the order of completions and the release of stalled warps are modelled.

Integer and floating-point classes draw on separate latency parameters, and the integer divide delay follows the data width. If the cycle in which a new completion would land is already booked on that slot, the head operation waits in its queue for a later cycle, so that no completion is ever overwritten. A warp-wide stall vector is kept beside the slots: external logic sets bits, and an operation that is both end-of-packet and flagged as fetch-stalling clears its warp's bit when it is taken. A class code outside the defined set is dropped and raises a sticky error output.

Top module: `exec_lat_sched`

## Requirements
- R1: Slots act independently in the same cycle; each slot takes at most one operation per cycle, always the oldest one in its queue.
- R2: Class codes 0 (integer arithmetic), 1 (branch), 2 (system call) and 3 (integer multiply) complete LAT_IMUL+1 cycles after the cycle in which they are taken: taken in cycle c, done_valid_o of that slot is high in cycle c+LAT_IMUL+1 with the op's tag on done_tag_o.
- R3: Class code 4 (integer divide) completes XLEN+1 cycles after it is taken.
- R4: Class code 8 (float compare / non-compute) completes 2 cycles after it is taken; codes 9 (fused multiply-add), 10 (float divide), 11 (square root) and 12 (convert) complete LAT_FMA+1, LAT_FDIV+1, LAT_FSQRT+1 and LAT_FCVT+1 cycles after it.
- R5: A head operation whose completion cycle is already booked on its slot is held in the queue and retried next cycle; every taken operation produces exactly one completion carrying its tag.
- R6: stall_set_i bits set stalled_o bits at the next edge; a taken operation with both end-of-packet and fetch-stall set clears its warp's bit at the next edge, clear winning over a simultaneous set; such a release occurs only for a warp whose bit is set; fetch-stall without end-of-packet clears nothing.
- R7: Class codes 5, 6, 7, 13, 14 and 15 are illegal: the operation is removed from the queue without any completion or stall release, and bad_class_o goes high at the next edge and stays high until reset.
- R8: Each queue holds QDEPTH entries; in_ready_o of a slot is low exactly when its queue is full, and a push while it is low is ignored (the op never completes).
- R9: After reset all queues are empty, in_ready_o is all ones, done_valid_o, stalled_o and bad_class_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | NUM_SLOTS | Push an operation into the slot's queue |
| in_cls_i | input | NUM_SLOTS*4 | Operation class code per slot |
| in_tag_i | input | NUM_SLOTS*TAG_W | Result tag per slot |
| in_wid_i | input | NUM_SLOTS*log2(NUM_WARPS) | Warp index per slot |
| in_eop_i | input | NUM_SLOTS | End-of-packet bit per slot |
| in_fstall_i | input | NUM_SLOTS | Fetch-stall bit per slot |
| in_ready_o | output | NUM_SLOTS | Slot queue can accept a push |
| stall_set_i | input | NUM_WARPS | Mark warps as stalled |
| done_valid_o | output | NUM_SLOTS | Completion present on the slot |
| done_tag_o | output | NUM_SLOTS*TAG_W | Tag of the completing operation |
| stalled_o | output | NUM_WARPS | Stalled-warp vector |
| bad_class_o | output | 1 | Sticky illegal-class indication |

## Verification
Checked on every cycle by assertions: that the number of booked completions changes only by the one leaving and the one entering (no overwrite on collision), that a queue pops only when non-empty and ignores pushes while full, that a release targets only a stalled warp and leaves its bit clear, and that the illegal-class flag rises after an illegal op and never drops. Only the bench scenarios show the exact delay of each class, the hold-and-retry timing when two completions aim at one cycle, the full-queue refusal and the clear-over-set priority, which the bench predicts with its own cycle model of queues, booked cycles and stall bits.

// File: rtl/exs_pkg.sv
package exs_pkg;

    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_IALU    = 4'd0,
        CLS_BRANCH  = 4'd1,
        CLS_SYSCALL = 4'd2,
        CLS_IMUL    = 4'd3,
        CLS_IDIV    = 4'd4,
        CLS_FNCP    = 4'd8,
        CLS_FMA     = 4'd9,
        CLS_FDIV    = 4'd10,
        CLS_FSQRT   = 4'd11,
        CLS_FCVT    = 4'd12
    } op_class_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/exs_lat_sel.sv
module exs_lat_sel
    import exs_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LAT_IMUL  = 2,
    parameter int LAT_FMA   = 3,
    parameter int LAT_FDIV  = 15,
    parameter int LAT_FSQRT = 19,
    parameter int LAT_FCVT  = 4,
    parameter int LAT_W     = 6
) (
    input  logic [CLS_W-1:0] cls_i,
    output logic [LAT_W-1:0] lat_o,
    output logic             legal_o
);

    always_comb begin
        legal_o = 1'b1;
        lat_o   = '0;
        case (cls_i)
            CLS_IALU, CLS_BRANCH, CLS_SYSCALL, CLS_IMUL:
                lat_o = LAT_W'(LAT_IMUL + 1);
            CLS_IDIV:  lat_o = LAT_W'(XLEN + 1);
            CLS_FNCP:  lat_o = LAT_W'(2);
            CLS_FMA:   lat_o = LAT_W'(LAT_FMA + 1);
            CLS_FDIV:  lat_o = LAT_W'(LAT_FDIV + 1);
            CLS_FSQRT: lat_o = LAT_W'(LAT_FSQRT + 1);
            CLS_FCVT:  lat_o = LAT_W'(LAT_FCVT + 1);
            default:   legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/exs_fifo.sv
module exs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    output logic         ready_o,
    input  logic         pop_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    assign ready_o = (st_q.cnt != CNT_W'(DEPTH));
    assign vld_o   = (st_q.cnt != '0);
    assign data_o  = st_q.mem[st_q.rd];
    assign do_push = push_i && ready_o;
    assign do_pop  = pop_i && vld_o;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a pop is only requested while an entry is present
    assert_pop_nonempty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> vld_o);

    // R8: a push against a full queue leaves the count as the pop alone makes it
    assert_full_push_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !ready_o) |=> (int'(st_q.cnt) == int'($past(st_q.cnt)) - int'($past(pop_i))));

endmodule

// File: rtl/exs_delay_line.sv
module exs_delay_line #(
    parameter int DEPTH = 33,
    parameter int LAT_W = 6,
    parameter int TAG_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ins_valid_i,
    input  logic [LAT_W-1:0] ins_lat_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    output logic             accept_o,
    output logic             out_valid_o,
    output logic [TAG_W-1:0] out_tag_o
);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } line_t;

    line_t st_d, st_q;
    logic  booked;

    // Entry i of the line completes i cycles from now; a latency L lands on
    // entry L before the shift, which is entry L-1 after it.
    always_comb begin
        booked = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.vld[i] && (int'(ins_lat_i) == i)) booked = 1'b1;
        end
    end

    assign accept_o = ins_valid_i && !booked;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH - 1; i++) begin
            st_d.vld[i] = st_q.vld[i+1];
            st_d.tag[i] = st_q.tag[i+1];
        end
        st_d.vld[DEPTH-1] = 1'b0;
        if (accept_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(ins_lat_i) == i + 1) begin
                    st_d.vld[i] = 1'b1;
                    st_d.tag[i] = ins_tag_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld[0];
    assign out_tag_o   = st_q.tag[0];

    // R5: booked completions change only by the one leaving and the one entering
    assert_no_lost_completion_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($countones(st_q.vld) ==
                  $countones($past(st_q.vld)) - int'($past(out_valid_o)) + int'($past(accept_o))));

    // R5: an accepted latency lies inside the window of the line
    assert_lat_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> (ins_lat_i != '0 && int'(ins_lat_i) <= DEPTH));

endmodule

// File: rtl/exec_lat_sched.sv
module exec_lat_sched
    import exs_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int QDEPTH    = 4,
    parameter int NUM_WARPS = 8,
    parameter int TAG_W     = 6,
    parameter int XLEN      = 32,
    parameter int LAT_IMUL  = 2,
    parameter int LAT_FMA   = 3,
    parameter int LAT_FDIV  = 15,
    parameter int LAT_FSQRT = 19,
    parameter int LAT_FCVT  = 4,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_SLOTS-1:0]       in_valid_i,
    input  logic [NUM_SLOTS*CLS_W-1:0] in_cls_i,
    input  logic [NUM_SLOTS*TAG_W-1:0] in_tag_i,
    input  logic [NUM_SLOTS*WID_W-1:0] in_wid_i,
    input  logic [NUM_SLOTS-1:0]       in_eop_i,
    input  logic [NUM_SLOTS-1:0]       in_fstall_i,
    output logic [NUM_SLOTS-1:0]       in_ready_o,
    input  logic [NUM_WARPS-1:0]       stall_set_i,
    output logic [NUM_SLOTS-1:0]       done_valid_o,
    output logic [NUM_SLOTS*TAG_W-1:0] done_tag_o,
    output logic [NUM_WARPS-1:0]       stalled_o,
    output logic                       bad_class_o
);

    localparam int DMAX = imax(imax(imax(LAT_IMUL + 1, XLEN + 1), imax(2, LAT_FMA + 1)),
                               imax(imax(LAT_FDIV + 1, LAT_FSQRT + 1), LAT_FCVT + 1));
    localparam int LAT_W   = $clog2(DMAX + 1);
    localparam int OFF_FS  = TAG_W;
    localparam int OFF_EOP = TAG_W + 1;
    localparam int OFF_WID = TAG_W + 2;
    localparam int OFF_CLS = TAG_W + 2 + WID_W;
    localparam int OPW     = OFF_CLS + CLS_W;

    typedef struct packed {
        logic [NUM_WARPS-1:0] stalled;
        logic                 bad;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_SLOTS-1:0] h_vld;
    logic [NUM_SLOTS-1:0] legal;
    logic [NUM_SLOTS-1:0] accept;
    logic [NUM_SLOTS-1:0] pop;
    logic [NUM_SLOTS-1:0] h_eop;
    logic [NUM_SLOTS-1:0] h_fs;
    logic [TAG_W-1:0]     h_tag [NUM_SLOTS];
    logic [WID_W-1:0]     h_wid [NUM_SLOTS];
    logic [LAT_W-1:0]     h_lat [NUM_SLOTS];
    logic [NUM_WARPS-1:0] release_w;
    logic                 bad_hit;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [OPW-1:0] in_op;
        logic [OPW-1:0] h_op;

        assign in_op = {in_cls_i[s*CLS_W +: CLS_W], in_wid_i[s*WID_W +: WID_W],
                        in_eop_i[s], in_fstall_i[s], in_tag_i[s*TAG_W +: TAG_W]};

        exs_fifo #(.W(OPW), .DEPTH(QDEPTH)) u_queue (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .push_i (in_valid_i[s]),
            .data_i (in_op),
            .ready_o(in_ready_o[s]),
            .pop_i  (pop[s]),
            .vld_o  (h_vld[s]),
            .data_o (h_op)
        );

        assign h_tag[s] = h_op[TAG_W-1:0];
        assign h_fs[s]  = h_op[OFF_FS];
        assign h_eop[s] = h_op[OFF_EOP];
        assign h_wid[s] = h_op[OFF_WID +: WID_W];

        exs_lat_sel #(
            .XLEN(XLEN), .LAT_IMUL(LAT_IMUL), .LAT_FMA(LAT_FMA), .LAT_FDIV(LAT_FDIV),
            .LAT_FSQRT(LAT_FSQRT), .LAT_FCVT(LAT_FCVT), .LAT_W(LAT_W)
        ) u_lat (
            .cls_i  (h_op[OFF_CLS +: CLS_W]),
            .lat_o  (h_lat[s]),
            .legal_o(legal[s])
        );

        exs_delay_line #(.DEPTH(DMAX), .LAT_W(LAT_W), .TAG_W(TAG_W)) u_line (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ins_valid_i(h_vld[s] && legal[s]),
            .ins_lat_i  (h_lat[s]),
            .ins_tag_i  (h_tag[s]),
            .accept_o   (accept[s]),
            .out_valid_o(done_valid_o[s]),
            .out_tag_o  (done_tag_o[s*TAG_W +: TAG_W])
        );

        // illegal heads are dropped at once; legal heads leave when booked
        assign pop[s] = h_vld[s] && (!legal[s] || accept[s]);
    end

    always_comb begin
        release_w = '0;
        bad_hit   = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (pop[s] && legal[s] && h_eop[s] && h_fs[s]) release_w[h_wid[s]] = 1'b1;
            if (h_vld[s] && !legal[s]) bad_hit = 1'b1;
        end
        st_d.stalled = (st_q.stalled | stall_set_i) & ~release_w;
        st_d.bad     = st_q.bad | bad_hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stalled_o   = st_q.stalled;
    assign bad_class_o = st_q.bad;

    // R6: a release only targets a warp that is currently marked stalled
    assert_release_needs_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|release_w) |-> ((release_w & ~stalled_o) == '0));

    // R6: a released warp reads as not stalled after the edge
    assert_release_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|release_w) |=> ((stalled_o & $past(release_w)) == '0));

    // R7: an illegal head raises the error flag
    assert_bad_on_illegal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_hit |=> bad_class_o);

    // R7: the error flag holds until reset
    assert_bad_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_class_o |=> bad_class_o);

endmodule

// File: tb/exec_lat_sched_tb_top.sv
module exec_lat_sched_tb_top;

    localparam int NS    = 2;
    localparam int QD    = 4;
    localparam int NW    = 8;
    localparam int TW    = 6;
    localparam int WW    = 3;
    localparam int XLEN  = 32;
    localparam int L_MUL = 2;
    localparam int L_FMA = 3;
    localparam int L_DIV = 15;
    localparam int L_SQ  = 19;
    localparam int L_CVT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NS-1:0]    in_valid;
    logic [NS*4-1:0]  in_cls;
    logic [NS*TW-1:0] in_tag;
    logic [NS*WW-1:0] in_wid;
    logic [NS-1:0]    in_eop;
    logic [NS-1:0]    in_fs;
    logic [NS-1:0]    in_ready;
    logic [NW-1:0]    stall_set;
    logic [NS-1:0]    done_valid;
    logic [NS*TW-1:0] done_tag;
    logic [NW-1:0]    stalled;
    logic             bad_class;

    exec_lat_sched #(
        .NUM_SLOTS(NS), .QDEPTH(QD), .NUM_WARPS(NW), .TAG_W(TW), .XLEN(XLEN),
        .LAT_IMUL(L_MUL), .LAT_FMA(L_FMA), .LAT_FDIV(L_DIV), .LAT_FSQRT(L_SQ), .LAT_FCVT(L_CVT)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .in_valid_i(in_valid), .in_cls_i(in_cls), .in_tag_i(in_tag), .in_wid_i(in_wid),
        .in_eop_i(in_eop), .in_fstall_i(in_fs), .in_ready_o(in_ready),
        .stall_set_i(stall_set), .done_valid_o(done_valid), .done_tag_o(done_tag),
        .stalled_o(stalled), .bad_class_o(bad_class)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int          mq_cls [NS][QD];
    int          mq_tag [NS][QD];
    int          mq_wid [NS][QD];
    bit          mq_eop [NS][QD];
    bit          mq_fs  [NS][QD];
    int          mcnt   [NS];
    bit          ev     [NS][64];
    int          et     [NS][64];
    int          done_cyc [NS][64];
    bit          rej    [NS][64];
    logic [NW-1:0] m_stall;
    bit          m_bad;
    bit          pend   [NW];
    int          rdy_low_seen;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int exp_lat(input int cls);
        case (cls)
            0, 1, 2, 3: return L_MUL + 1;
            4:          return XLEN + 1;
            8:          return 2;
            9:          return L_FMA + 1;
            10:         return L_DIV + 1;
            11:         return L_SQ + 1;
            12:         return L_CVT + 1;
            default:    return -1;
        endcase
    endfunction

    function automatic string lat_req(input int cls);
        if (cls <= 3) return "R2";
        if (cls == 4) return "R3";
        return "R4";
    endfunction

    task automatic clear_inputs();
        in_valid = '0; in_cls = '0; in_tag = '0; in_wid = '0;
        in_eop = '0; in_fs = '0; stall_set = '0;
    endtask

    task automatic push(input int s, input int cls, input int tag, input int wid, input bit eop, input bit fs);
        in_valid[s] = 1'b1;
        in_cls[s*4 +: 4] = 4'(cls);
        in_tag[s*TW +: TW] = TW'(tag);
        in_wid[s*WW +: WW] = WW'(wid);
        in_eop[s] = eop;
        in_fs[s] = fs;
    endtask

    task automatic model_edge();
        logic [NW-1:0] clr;
        clr = '0;
        for (int s = 0; s < NS; s++) begin
            int c0 = mcnt[s];
            bit popped = 0;
            if (c0 > 0) begin
                int lat = exp_lat(mq_cls[s][0]);
                if (lat < 0) begin
                    popped = 1; m_bad = 1;
                end else if (!ev[s][(cyc + lat) % 64]) begin
                    ev[s][(cyc + lat) % 64] = 1;
                    et[s][(cyc + lat) % 64] = mq_tag[s][0];
                    popped = 1;
                    if (mq_eop[s][0] && mq_fs[s][0]) begin
                        clr[mq_wid[s][0]] = 1'b1;
                        pend[mq_wid[s][0]] = 0;
                    end
                end
            end
            if (popped) begin
                for (int k = 0; k < QD - 1; k++) begin
                    mq_cls[s][k] = mq_cls[s][k+1]; mq_tag[s][k] = mq_tag[s][k+1];
                    mq_wid[s][k] = mq_wid[s][k+1]; mq_eop[s][k] = mq_eop[s][k+1];
                    mq_fs[s][k]  = mq_fs[s][k+1];
                end
                mcnt[s]--;
            end
            if (in_valid[s]) begin
                if (c0 < QD) begin
                    mq_cls[s][mcnt[s]] = int'(in_cls[s*4 +: 4]);
                    mq_tag[s][mcnt[s]] = int'(in_tag[s*TW +: TW]);
                    mq_wid[s][mcnt[s]] = int'(in_wid[s*WW +: WW]);
                    mq_eop[s][mcnt[s]] = in_eop[s];
                    mq_fs[s][mcnt[s]]  = in_fs[s];
                    mcnt[s]++;
                end else begin
                    rej[s][int'(in_tag[s*TW +: TW])] = 1;
                    if (in_eop[s] && in_fs[s]) pend[int'(in_wid[s*WW +: WW])] = 0;
                end
            end
        end
        m_stall = (m_stall | stall_set) & ~clr;
    endtask

    task automatic check_outputs();
        for (int s = 0; s < NS; s++) begin
            int slot = cyc % 64;
            chk(done_valid[s] == ev[s][slot], "R5", $sformatf("done_valid slot %0d", s),
                int'(done_valid[s]), int'(ev[s][slot]));
            if (ev[s][slot])
                chk(int'(done_tag[s*TW +: TW]) == et[s][slot], "R5", $sformatf("done_tag slot %0d", s),
                    int'(done_tag[s*TW +: TW]), et[s][slot]);
            if (done_valid[s]) done_cyc[s][int'(done_tag[s*TW +: TW])] = cyc;
            chk(in_ready[s] == (mcnt[s] < QD), "R8", $sformatf("in_ready slot %0d", s),
                int'(in_ready[s]), int'(mcnt[s] < QD));
            if (!in_ready[s]) rdy_low_seen++;
            ev[s][slot] = 0;
        end
        chk(stalled == m_stall, "R6", "stalled vector", int'(stalled), int'(m_stall));
        chk(bad_class == m_bad, "R7", "bad_class", int'(bad_class), int'(m_bad));
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check_outputs();
        clear_inputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_done();
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < 64; t++) begin
                done_cyc[s][t] = -1; rej[s][t] = 0;
            end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int lcls [10] = '{0, 1, 2, 3, 4, 8, 9, 10, 11, 12};
        int p;
        int rtag [NS];
        for (int s = 0; s < NS; s++) begin
            mcnt[s] = 0; rtag[s] = 0;
            for (int t = 0; t < 64; t++) begin ev[s][t] = 0; et[s][t] = 0; end
        end
        for (int w = 0; w < NW; w++) pend[w] = 0;
        m_stall = '0; m_bad = 0; rdy_low_seen = 0;
        clear_done();
        clear_inputs();
        void'($urandom(32'd20240131));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: state right after reset
        chk(in_ready == '1, "R9", "in_ready after reset", int'(in_ready), 3);
        chk(done_valid == '0, "R9", "done_valid after reset", int'(done_valid), 0);
        chk(stalled == '0, "R9", "stalled after reset", int'(stalled), 0);
        chk(bad_class == 1'b0, "R9", "bad_class after reset", int'(bad_class), 0);
        check_outputs();

        // R1 R2 R3 R4: exact delay per class, both slots at once
        for (int i = 0; i < 10; i++) begin
            clear_done();
            p = cyc;
            push(0, lcls[i], 10 + i, 0, 0, 0);
            push(1, lcls[9 - i], 30 + i, 1, 0, 0);
            step();
            idle(40);
            chk(done_cyc[0][10 + i] == p + 1 + exp_lat(lcls[i]), lat_req(lcls[i]),
                $sformatf("done cycle class %0d", lcls[i]), done_cyc[0][10 + i] - p, 1 + exp_lat(lcls[i]));
            chk(done_cyc[1][30 + i] == p + 1 + exp_lat(lcls[9 - i]), "R1",
                $sformatf("slot1 done cycle class %0d", lcls[9 - i]), done_cyc[1][30 + i] - p,
                1 + exp_lat(lcls[9 - i]));
        end

        // R5: convert then fused multiply-add aim at the same cycle
        clear_done();
        p = cyc;
        push(0, 12, 40, 0, 0, 0);
        step();
        push(0, 9, 41, 0, 0, 0);
        step();
        idle(20);
        chk(done_cyc[0][40] == p + 6, "R5", "first of colliding pair", done_cyc[0][40] - p, 6);
        chk(done_cyc[0][41] == p + 7, "R5", "held op after collision", done_cyc[0][41] - p, 7);

        // R8: fill slot 1 behind a held divide
        clear_done();
        rdy_low_seen = 0;
        for (int k = 0; k < 10; k++) begin push(1, 11, k, 2, 0, 0); step(); end
        for (int k = 0; k < 10; k++) begin push(1, 10, 20 + k, 2, 0, 0); step(); end
        idle(60);
        chk(rdy_low_seen > 0, "R8", "queue reached full", rdy_low_seen, 1);
        for (int k = 0; k < 10; k++) begin
            if (rej[1][20 + k])
                chk(done_cyc[1][20 + k] == -1, "R8", "refused push completed", done_cyc[1][20 + k], -1);
            else
                chk(done_cyc[1][20 + k] != -1, "R8", "accepted push missing", done_cyc[1][20 + k], 0);
        end

        // R6: release on end-of-packet plus fetch-stall
        stall_set[3] = 1'b1;
        step();
        chk(stalled[3] == 1'b1, "R6", "bit set by stall_set", int'(stalled[3]), 1);
        pend[3] = 1;
        push(0, 0, 51, 3, 1, 1);
        step();
        step();
        chk(stalled[3] == 1'b0, "R6", "bit cleared by release", int'(stalled[3]), 0);
        // R6: fetch-stall without end-of-packet clears nothing
        stall_set[6] = 1'b1;
        step();
        push(0, 3, 52, 6, 0, 1);
        idle(3);
        chk(stalled[6] == 1'b1, "R6", "non-eop op kept bit", int'(stalled[6]), 1);
        // R6: clear wins over a set in the same cycle
        idle(10);
        stall_set[5] = 1'b1;
        step();
        pend[5] = 1;
        push(0, 8, 53, 5, 1, 1);
        step();
        stall_set[5] = 1'b1;
        step();
        chk(stalled[5] == 1'b0, "R6", "clear over simultaneous set", int'(stalled[5]), 0);

        // R7: illegal class dropped, flag raised
        clear_done();
        push(0, 5, 50, 0, 0, 0);
        push(1, 14, 50, 0, 0, 0);
        step();
        idle(40);
        chk(done_cyc[0][50] == -1, "R7", "illegal op completed slot 0", done_cyc[0][50], -1);
        chk(done_cyc[1][50] == -1, "R7", "illegal op completed slot 1", done_cyc[1][50], -1);
        chk(bad_class == 1'b1, "R7", "bad_class after illegal op", int'(bad_class), 1);

        // random traffic against the model
        for (int n = 0; n < 2500; n++) begin
            for (int s = 0; s < NS; s++) begin
                if ($urandom % 4 != 0) begin
                    int cls = ($urandom % 20 == 0) ? 13 : lcls[$urandom % 10];
                    int wid = int'($urandom % NW);
                    bit eop = bit'($urandom % 2);
                    bit fs = ($urandom % 3 == 0);
                    if (eop && fs) begin
                        if (exp_lat(cls) > 0 && !pend[wid]) begin
                            pend[wid] = 1;
                            stall_set[wid] = 1'b1;
                        end else begin
                            fs = 0;
                        end
                    end
                    push(s, cls, rtag[s], wid, eop, fs);
                    rtag[s] = (rtag[s] + 1) % 64;
                end
            end
            if ($urandom % 8 == 0) stall_set[$urandom % NW] = 1'b1;
            step();
        end
        idle(60);

        finished = 1;
        summary();
        $finish;
    end

endmodule